// File: doc/BRIEF.md
# Multithread Oldest-Head / Youngest-Tail Selector

In a reorder buffer shared by several hardware threads, each thread keeps its own in-order list of instructions. This block looks at a per-thread summary of those lists (whether the thread is active, whether its list holds anything, the sequence number at its head and at its tail, and whether its head entry is ready to commit). From that summary it names the thread that holds the oldest instruction in the whole buffer and the thread that holds the youngest one.

It also raises a single flag when at least one thread could commit this cycle. The selection logic is purely combinational. All outputs are registered, so they follow the inputs with one cycle of latency. The retire and squash logic updates the per-thread summary, and the registered outputs then reflect that update on the following cycle.

Top module: `rob_head_tail_sel`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is 0 after that edge.
- R2: Outputs are registered. A change on any input appears on the outputs only after the next rising clock edge, and the outputs hold steady until that edge.
- R3: A thread takes part in either search only if both its `thr_active` bit and its `thr_nonempty` bit are 1. All other threads are ignored, whatever their sequence numbers are.
- R4: When at least one thread takes part, `oldest_valid` is 1 and `oldest_tid` is the participating thread with the smallest `thr_head_seq`.
- R5: When at least one thread takes part, `youngest_valid` is 1 and `youngest_tid` is the participating thread with the largest `thr_tail_seq`.
- R6: Candidates are visited in ascending thread index. The first participant is taken without comparison. Another thread replaces it only on a strict improvement, so when two values are equal the lower thread index wins.
- R7: When no thread takes part, `oldest_valid` and `youngest_valid` are 0, and `oldest_tid` and `youngest_tid` are 0.
- R8: `commit_ok` is 1 exactly when some thread has `thr_active`, `thr_nonempty` and `thr_head_ready` all set to 1.
- R9: Sequence numbers are compared as unsigned values of `SEQ_W` bits. Thread t uses bits [t*SEQ_W +: SEQ_W] of each flattened sequence bus, and bit t of each per-thread mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_active | input | NUM_THREADS | Per-thread active bit |
| thr_nonempty | input | NUM_THREADS | Per-thread list holds at least one entry |
| thr_head_ready | input | NUM_THREADS | Per-thread head entry ready to commit |
| thr_head_seq | input | NUM_THREADS*SEQ_W | Flattened head sequence numbers |
| thr_tail_seq | input | NUM_THREADS*SEQ_W | Flattened tail sequence numbers |
| oldest_valid | output | 1 | A global head exists |
| oldest_tid | output | TID_W | Thread holding the oldest instruction |
| youngest_valid | output | 1 | A global tail exists |
| youngest_tid | output | TID_W | Thread holding the youngest instruction |
| commit_ok | output | 1 | Some eligible thread has a ready head |

## Verification
The bench targets threads that are active but empty, or non-empty but inactive, and that carry the most extreme sequence numbers. A design that forgot either qualifier would point the head or tail at a thread with nothing to retire. It drives equal sequence numbers on several threads, where a non-strict compare or a descending scan would report a higher thread index. It also checks the all-idle case, where a stale or non-zero thread index would leak out. Finally, it covers a thread whose head is ready but which is inactive or empty, where a loose commit flag would allow a bogus retire.

// File: rtl/rob_sel_pkg.sv
// Shared helpers for the reorder-buffer head/tail selector.
// Assumes at least one thread; index width never collapses to zero.
package rob_sel_pkg;
    function automatic int tid_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rob_sel_qualify.sv
// Decides which threads take part in the searches and whether any
// thread may commit. Assumes inputs are stable within a cycle.
module rob_sel_qualify #(
    parameter int NUM_THREADS = 4
) (
    input  logic [NUM_THREADS-1:0] active,
    input  logic [NUM_THREADS-1:0] nonempty,
    input  logic [NUM_THREADS-1:0] head_ready,
    output logic [NUM_THREADS-1:0] eligible,
    output logic                   any_ready
);
    // Eligibility per thread and the commit reduction.
    always_comb begin
        eligible  = active & nonempty;
        any_ready = |(eligible & head_ready);
    end
endmodule

// File: rtl/rob_sel_scan.sv
// Ordered scan over thread candidates: the first eligible thread is taken
// as is, later ones replace it only on strict improvement. PICK_LOWER
// selects a minimum search (1) or a maximum search (0).
module rob_sel_scan #(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 16,
    parameter bit PICK_LOWER  = 1'b1,
    localparam int TID_W      = rob_sel_pkg::tid_width(NUM_THREADS)
) (
    input  logic [NUM_THREADS-1:0]       eligible,
    input  logic [NUM_THREADS*SEQ_W-1:0] seq_flat,
    output logic                         found,
    output logic [TID_W-1:0]             pick
);
    logic [SEQ_W-1:0] seq [NUM_THREADS];
    logic [NUM_THREADS-1:0] better;
    logic [SEQ_W-1:0] best;

    // Unpack the flattened sequence bus.
    genvar g;
    generate
        for (g = 0; g < NUM_THREADS; g++) begin : g_unpack
            assign seq[g] = seq_flat[g*SEQ_W +: SEQ_W];
        end
    endgenerate

    // Walk threads in ascending index, keeping the best candidate.
    always_comb begin
        found  = 1'b0;
        pick   = '0;
        best   = '0;
        better = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (PICK_LOWER) better[t] = (seq[t] < best);
            else            better[t] = (seq[t] > best);
            if (eligible[t] && (!found || better[t])) begin
                found = 1'b1;
                pick  = TID_W'(t);
                best  = seq[t];
            end
        end
    end
endmodule

// File: rtl/rob_head_tail_sel.sv
// Top: finds the global oldest-head and youngest-tail threads of a
// thread-split reorder buffer and the can-commit flag, registered once.
// Assumes sequence numbers are unique in normal use; ties break low.
module rob_head_tail_sel #(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 16,
    localparam int TID_W      = rob_sel_pkg::tid_width(NUM_THREADS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_THREADS-1:0]       thr_active,
    input  logic [NUM_THREADS-1:0]       thr_nonempty,
    input  logic [NUM_THREADS-1:0]       thr_head_ready,
    input  logic [NUM_THREADS*SEQ_W-1:0] thr_head_seq,
    input  logic [NUM_THREADS*SEQ_W-1:0] thr_tail_seq,
    output logic                         oldest_valid,
    output logic [TID_W-1:0]             oldest_tid,
    output logic                         youngest_valid,
    output logic [TID_W-1:0]             youngest_tid,
    output logic                         commit_ok
);
    logic [NUM_THREADS-1:0] eligible;
    logic                   any_ready;
    logic                   head_found, tail_found;
    logic [TID_W-1:0]       head_pick, tail_pick;

    rob_sel_qualify #(.NUM_THREADS(NUM_THREADS)) u_qual (
        .active     (thr_active),
        .nonempty   (thr_nonempty),
        .head_ready (thr_head_ready),
        .eligible   (eligible),
        .any_ready  (any_ready)
    );

    rob_sel_scan #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .PICK_LOWER(1'b1)) u_head (
        .eligible (eligible),
        .seq_flat (thr_head_seq),
        .found    (head_found),
        .pick     (head_pick)
    );

    rob_sel_scan #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .PICK_LOWER(1'b0)) u_tail (
        .eligible (eligible),
        .seq_flat (thr_tail_seq),
        .found    (tail_found),
        .pick     (tail_pick)
    );

    // Output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oldest_valid   <= 1'b0;
            oldest_tid     <= '0;
            youngest_valid <= 1'b0;
            youngest_tid   <= '0;
            commit_ok      <= 1'b0;
        end else begin
            oldest_valid   <= head_found;
            oldest_tid     <= head_pick;
            youngest_valid <= tail_found;
            youngest_tid   <= tail_pick;
            commit_ok      <= any_ready;
        end
    end
endmodule

// File: rtl/rob_head_tail_sel_chk.sv
// Checker for rob_head_tail_sel: keeps its own one-cycle copy of the
// inputs and relates the registered outputs to it.
module rob_head_tail_sel_chk #(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 16,
    localparam int TID_W      = rob_sel_pkg::tid_width(NUM_THREADS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_THREADS-1:0]       thr_active,
    input  logic [NUM_THREADS-1:0]       thr_nonempty,
    input  logic [NUM_THREADS-1:0]       thr_head_ready,
    input  logic [NUM_THREADS*SEQ_W-1:0] thr_head_seq,
    input  logic [NUM_THREADS*SEQ_W-1:0] thr_tail_seq,
    input  logic                         oldest_valid,
    input  logic [TID_W-1:0]             oldest_tid,
    input  logic                         youngest_valid,
    input  logic [TID_W-1:0]             youngest_tid,
    input  logic                         commit_ok
);
    logic                   armed;
    logic [NUM_THREADS-1:0] q_prev, r_prev;
    logic [SEQ_W-1:0]       hs_prev [NUM_THREADS];
    logic [SEQ_W-1:0]       ts_prev [NUM_THREADS];

    // Capture last cycle's inputs and whether reset was released then.
    always_ff @(posedge clk) begin
        armed  <= rst_n;
        q_prev <= thr_active & thr_nonempty;
        r_prev <= thr_active & thr_nonempty & thr_head_ready;
        for (int t = 0; t < NUM_THREADS; t++) begin
            hs_prev[t] <= thr_head_seq[t*SEQ_W +: SEQ_W];
            ts_prev[t] <= thr_tail_seq[t*SEQ_W +: SEQ_W];
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!oldest_valid && !youngest_valid && !commit_ok)); // R1

    AST_HEAD_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        armed && oldest_valid |-> q_prev[oldest_tid]); // R3

    AST_TAIL_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        armed && youngest_valid |-> q_prev[youngest_tid]); // R3

    AST_VALID_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (oldest_valid == (|q_prev)) && (youngest_valid == (|q_prev))); // R7

    AST_IDLE_TID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !oldest_valid |-> (oldest_tid == '0) && (youngest_tid == '0)); // R7

    AST_COMMIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> commit_ok == (|r_prev)); // R8

    genvar g;
    generate
        for (g = 0; g < NUM_THREADS; g++) begin : g_thr
            AST_HEAD_IS_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
                armed && oldest_valid && q_prev[g] |-> hs_prev[g] >= hs_prev[oldest_tid]); // R4

            AST_TAIL_IS_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_n)
                armed && youngest_valid && q_prev[g] |-> ts_prev[g] <= ts_prev[youngest_tid]); // R5

            AST_HEAD_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                armed && oldest_valid && q_prev[g] && (oldest_tid > TID_W'(g))
                |-> hs_prev[g] != hs_prev[oldest_tid]); // R6

            AST_TAIL_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                armed && youngest_valid && q_prev[g] && (youngest_tid > TID_W'(g))
                |-> ts_prev[g] != ts_prev[youngest_tid]); // R6
        end
    endgenerate
endmodule

bind rob_head_tail_sel rob_head_tail_sel_chk #(
    .NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W)
) u_chk (.*);

// File: tb/rob_head_tail_sel_bench.sv
module rob_head_tail_sel_bench;
    localparam int N  = 4;
    localparam int W  = 16;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] act = '0, ne = '0, rdy = '0;
    logic [W-1:0] hs [N];
    logic [W-1:0] ts [N];
    logic [N*W-1:0] hs_flat, ts_flat;
    logic oldest_valid, youngest_valid, commit_ok;
    logic [TW-1:0] oldest_tid, youngest_tid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Expected outputs (behavioural model state).
    bit e_hv, e_tv, e_ck;
    int e_ht, e_tt;

    always #5 clk = ~clk;

    always_comb begin
        for (int t = 0; t < N; t++) begin
            hs_flat[t*W +: W] = hs[t];
            ts_flat[t*W +: W] = ts[t];
        end
    end

    rob_head_tail_sel #(.NUM_THREADS(N), .SEQ_W(W)) u_rob_head_tail_sel (
        .clk(clk), .rst_n(rst_n),
        .thr_active(act), .thr_nonempty(ne), .thr_head_ready(rdy),
        .thr_head_seq(hs_flat), .thr_tail_seq(ts_flat),
        .oldest_valid(oldest_valid), .oldest_tid(oldest_tid),
        .youngest_valid(youngest_valid), .youngest_tid(youngest_tid),
        .commit_ok(commit_ok)
    );

    task automatic chk(input string req, input string what, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, actual, expected, $time);
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, "oldest_valid",   int'(oldest_valid),   int'(e_hv));
        chk(req, "oldest_tid",     int'(oldest_tid),     e_ht);
        chk(req, "youngest_valid", int'(youngest_valid), int'(e_tv));
        chk(req, "youngest_tid",   int'(youngest_tid),   e_tt);
        chk(req, "commit_ok",      int'(commit_ok),      int'(e_ck));
    endtask

    // Model: gather eligible threads into a queue, then search it.
    task automatic model();
        int q [$];
        e_hv = 0; e_tv = 0; e_ck = 0; e_ht = 0; e_tt = 0;
        if (!rst_n) return;
        for (int t = 0; t < N; t++)
            if (act[t] && ne[t]) begin
                q.push_back(t);
                if (rdy[t]) e_ck = 1;
            end
        if (q.size() == 0) return;
        e_hv = 1; e_tv = 1;
        e_ht = q[0]; e_tt = q[0];
        foreach (q[i]) begin
            if (hs[q[i]] < hs[e_ht]) e_ht = q[i];
            if (ts[q[i]] > ts[e_tt]) e_tt = q[i];
        end
    endtask

    // Inputs were just changed at a falling edge: outputs must not move
    // yet (R2); after the next rising edge they must match the model.
    task automatic apply(input string req);
        #1;
        compare_all("R2");
        model();
        @(negedge clk);
        compare_all(req);
    endtask

    task automatic set_thr(input int t, input bit a, input bit n, input bit r,
                           input int h, input int tl);
        act[t] = a; ne[t] = n; rdy[t] = r;
        hs[t] = W'(h); ts[t] = W'(tl);
    endtask

    initial begin
        for (int t = 0; t < N; t++) begin hs[t] = '0; ts[t] = '0; end
        e_hv = 0; e_tv = 0; e_ck = 0; e_ht = 0; e_tt = 0;
        @(negedge clk);
        // R1: reset state, with busy inputs present.
        for (int t = 0; t < N; t++) set_thr(t, 1, 1, 1, 10 + t, 20 + t);
        apply("R1");
        apply("R1");
        rst_n = 1'b1;
        for (int t = 0; t < N; t++) set_thr(t, 0, 0, 0, 0, 0);
        // R7: nothing eligible.
        apply("R7");
        // R4/R5: all eligible, distinct values.
        set_thr(0, 1, 1, 0, 40, 90);
        set_thr(1, 1, 1, 0, 12, 70);
        set_thr(2, 1, 1, 0, 33, 95);
        set_thr(3, 1, 1, 0, 25, 60);
        apply("R4");
        apply("R5");
        // R3: extreme values on inactive and on empty threads are ignored.
        set_thr(1, 0, 1, 1, 1, 999);
        set_thr(2, 1, 0, 1, 2, 998);
        apply("R3");
        // R8: ready only on ineligible threads gives no commit.
        chk("R8", "commit_ok ineligible", int'(commit_ok), 0);
        set_thr(3, 1, 1, 1, 25, 60);
        apply("R8");
        // R6: ties break towards the lower index.
        for (int t = 0; t < N; t++) set_thr(t, 1, 1, 0, 50, 80);
        apply("R6");
        set_thr(0, 0, 1, 0, 50, 80);
        apply("R6");
        // R9: unsigned compare at the top of the range.
        set_thr(0, 1, 1, 0, 16'hFFFF, 16'hFFFF);
        set_thr(1, 1, 1, 0, 16'h8000, 16'h7FFF);
        set_thr(2, 1, 1, 0, 16'h0001, 16'h8001);
        set_thr(3, 0, 0, 0, 0, 0);
        apply("R9");
        // R7: single thread, then all idle again.
        for (int t = 0; t < N; t++) set_thr(t, 0, 0, 0, 0, 0);
        set_thr(3, 1, 1, 1, 7, 7);
        apply("R4");
        set_thr(3, 1, 0, 1, 7, 7);
        apply("R7");
        // Mid-run reset clears everything (R1).
        for (int t = 0; t < N; t++) set_thr(t, 1, 1, 1, t, t);
        rst_n = 1'b0;
        apply("R1");
        rst_n = 1'b1;
        // Random patterns with a narrow value range to provoke ties.
        for (int k = 0; k < 400; k++) begin
            for (int t = 0; t < N; t++)
                set_thr(t, $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                        $urandom_range(0, 1) == 1, $urandom_range(0, 7), $urandom_range(0, 7));
            apply((k % 2 == 0) ? "R4" : "R5");
        end
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule